// File: doc/BRIEF.md
# Synchronized Master-Slave Timer Pair

Two up-counting timers share one clock. Each timer has three settings: its own prescale divider, its own period and its own count. The first timer is the master. It drives a trigger line, and a mode field chooses what that line carries: either a one-clock pulse each time the master's counter wraps, or the master's run enable. The second timer is the slave. It can take that line as its trigger input, and then either its enable or its counting follows the trigger.

In trigger mode, a rising trigger turns the slave's enable bit on. The slave then counts onward from whatever value it already holds, and it stops only when software clears the enable. In gated mode, the slave advances only while the trigger is high. Both modes raise a sticky flag, which software clears by writing a zero to it. All settings go through a single-cycle write port. A combinational read port returns any register.

Top module: `sync_timer_pair`

## Requirements
- R1: After reset, every register reads 0. This covers both counters, both enables, all mode fields and the flag. `trig_out` is low.
- R2: A running counter with prescale value P advances once every P+1 clocks. After it reaches its period value, its next step goes to 0.
- R3: `trig_out` depends on the master mode field, bits [3:1] at address 0:
  - With 010, it carries a one-clock pulse during the cycle that ends with the master's wrap.
  - With 001, it follows the master enable.
  - With any other value, it is low.
- R4: Only trigger-select 00010 (bits [8:4] at address 4) connects `trig_out` to the slave. With any other value, the slave sees a low trigger.
- R5: When the slave mode (bits [3:1] at address 4) is 110, a rising trigger sets the slave enable at the next edge. The slave then counts on from its held value, not from 0.
- R6: In trigger mode the slave enable stays set until software writes 0 to it. Later triggers never clear it.
- R7: Each slave trigger event sets the flag (bit 0 at address 8). Writing 0 there clears the flag, and writing 1 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R8: When the slave mode is 101 and the slave enable is set, the slave counts only while its trigger is high and holds its value while the trigger is low. The flag is set on both the rising and the falling trigger.
- R9: When the slave mode is 000, the trigger changes neither the slave enable nor the flag.
- R10: A write to a count register takes effect at that edge and restarts that timer's prescale phase.
- R11: The register map:
  - Address 0: master control, {mode[3:1], enable[0]}.
  - Addresses 1, 2, 3: master prescale, period and count.
  - Address 4: slave control, {select[8:4], mode[3:1], enable[0]}.
  - Addresses 5, 6, 7: slave prescale, period and count.
  - Address 8: flag.
  - Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_addr | input | AW | Write register address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read register address |
| rd_data | output | DW | Read data for `rd_addr`, zero-extended |
| trig_out | output | 1 | Master trigger line |

## Verification
The assertions assume that a write to a control, count or flag register may override a hardware effect in the same cycle. Each property that such a write could override is therefore disabled during that write. The assertions also assume that DW is at least 9, so that every control field fits on the write port. The stimulus issues at most one write per cycle, and only to mapped addresses. It drives every write half a period before the edge. When a check depends on exact trigger timing, the stimulus first stops the master, or rewrites its count, so that the trigger cycle follows from the written values alone.

// File: rtl/sync_timer_pair.sv
module sync_timer_pair #(
  parameter int CW = 8,
  parameter int DW = 16,
  parameter int AW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          trig_out
);
  localparam int NREG = 9;
  localparam logic [2:0] MM_ENABLE = 3'b001;
  localparam logic [2:0] MM_UPDATE = 3'b010;
  localparam logic [2:0] SM_GATED  = 3'b101;
  localparam logic [2:0] SM_TRIG   = 3'b110;
  localparam logic [4:0] TS_MASTER = 5'b00010;

  logic            m_en, s_en, trg_q, flag;
  logic [2:0]      mms, sms;
  logic [4:0]      tsel;
  logic [1:0][CW-1:0] psc, arr, cnt, pcnt;
  logic [1:0]      run, tick, wrap;
  logic [NREG-1:0] we;
  logic            trg, rise, fall, hw_start, flag_set, flag_clr;

  always_comb
    for (int a = 0; a < NREG; a++) we[a] = wr_en && (wr_addr == AW'(a));

  assign run[0] = m_en;
  assign run[1] = s_en && (sms != SM_GATED || trg);

  always_comb
    for (int i = 0; i < 2; i++) begin
      tick[i] = run[i] && (pcnt[i] == psc[i]);
      wrap[i] = tick[i] && (cnt[i] == arr[i]);
    end

  assign trig_out = (mms == MM_UPDATE) ? wrap[0] :
                    (mms == MM_ENABLE) ? m_en : 1'b0;
  assign trg      = (tsel == TS_MASTER) && trig_out;
  assign rise     = trg && !trg_q;
  assign fall     = !trg && trg_q;
  assign hw_start = (sms == SM_TRIG) && rise;
  assign flag_set = hw_start || ((sms == SM_GATED) && (rise || fall));
  assign flag_clr = we[8] && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 1'b0; s_en <= 1'b0; trg_q <= 1'b0; flag <= 1'b0;
      mms <= '0; sms <= '0; tsel <= '0;
      psc <= '0; arr <= '0; cnt <= '0; pcnt <= '0;
    end else begin
      trg_q <= trg;
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (we[0]) begin
        m_en <= wr_data[0];
        mms  <= wr_data[3:1];
      end
      if (we[4]) begin
        s_en <= wr_data[0];
        sms  <= wr_data[3:1];
        tsel <= wr_data[8:4];
      end
      if (hw_start) s_en <= 1'b1;
      for (int i = 0; i < 2; i++) begin
        if (we[4*i+1]) psc[i] <= wr_data[CW-1:0];
        if (we[4*i+2]) arr[i] <= wr_data[CW-1:0];
        if (we[4*i+3]) begin
          cnt[i]  <= wr_data[CW-1:0];
          pcnt[i] <= '0;
        end else if (tick[i]) begin
          pcnt[i] <= '0;
          cnt[i]  <= wrap[i] ? '0 : cnt[i] + 1'b1;
        end else if (run[i]) begin
          pcnt[i] <= pcnt[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(0): rd_data[3:0]    = {mms, m_en};
      AW'(1): rd_data[CW-1:0] = psc[0];
      AW'(2): rd_data[CW-1:0] = arr[0];
      AW'(3): rd_data[CW-1:0] = cnt[0];
      AW'(4): rd_data[8:0]    = {tsel, sms, s_en};
      AW'(5): rd_data[CW-1:0] = psc[1];
      AW'(6): rd_data[CW-1:0] = arr[1];
      AW'(7): rd_data[CW-1:0] = cnt[1];
      AW'(8): rd_data[0]      = flag;
      default: rd_data = '0;
    endcase
  end
endmodule

module stp_checker #(
  parameter int CW = 8,
  parameter int DW = 16,
  parameter int AW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          trg,
  input logic          s_en,
  input logic          flag,
  input logic [2:0]    sms,
  input logic          m_tick,
  input logic [CW-1:0] m_cnt,
  input logic [CW-1:0] m_arr,
  input logic [CW-1:0] s_cnt
);
  logic wr_sctl, wr_mcnt, wr_scnt, wr_fclr;
  assign wr_sctl = wr_en && (wr_addr == AW'(4));
  assign wr_mcnt = wr_en && (wr_addr == AW'(3));
  assign wr_scnt = wr_en && (wr_addr == AW'(7));
  assign wr_fclr = wr_en && (wr_addr == AW'(8)) && !wr_data[0];

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tick && m_cnt == m_arr && !wr_mcnt) |=> (m_cnt == '0));
  p_trigger_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sms == 3'b110 && $rose(trg)) |=> s_en);
  p_enable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && !wr_sctl) |=> s_en);
  p_flag_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_fclr) |=> flag);
  p_gated_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sms == 3'b101 && !trg && !wr_scnt) |=> $stable(s_cnt));
  p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sms == 3'b000 && !wr_sctl) |=> $stable(s_en));
endmodule

bind sync_timer_pair stp_checker #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .trg(trg), .s_en(s_en), .flag(flag), .sms(sms),
  .m_tick(tick[0]), .m_cnt(cnt[0]), .m_arr(arr[0]), .s_cnt(cnt[1])
);

// File: tb/sync_timer_pair_test.sv
module sync_timer_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8, DW = 16, AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          trig_out;
  int nchk = 0;
  int errs = 0;

  sync_timer_pair #(.CW(CW), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .trig_out(trig_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    int v, v2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(a, v);
      check($sformatf("R1 reset reg %0d", a), v, 0);
    end
    check("R1 trig_out after reset", int'(trig_out), 0);

    // R2 / R3 sweep of prescale and period on the master
    for (int p = 0; p < 3; p++)
      for (int ar = 1; ar < 4; ar++) begin
        wr(0, 0); wr(3, 0); wr(1, p); wr(2, ar);
        wr(0, 5);
        rd(3, v);
        check("R2 count at start", v, 0);
        for (int n = 1; n <= 2 * (p + 1) * (ar + 1); n++) begin
          step(1);
          rd(3, v);
          check($sformatf("R2 p=%0d per=%0d n=%0d", p, ar, n), v, (n / (p + 1)) % (ar + 1));
          check($sformatf("R3 update pulse p=%0d per=%0d n=%0d", p, ar, n), int'(trig_out),
                ((n + 1) % ((p + 1) * (ar + 1)) == 0) ? 1 : 0);
        end
      end

    // R10 count write while running restarts the prescale phase
    wr(0, 0); wr(1, 2); wr(2, 3); wr(3, 0); wr(0, 5);
    step(7);
    wr(3, 2);
    rd(3, v);
    check("R10 written count", v, 2);
    for (int n = 1; n <= 12; n++) begin
      step(1);
      rd(3, v);
      check($sformatf("R10 after write n=%0d", n), v, (2 + n / 3) % 4);
    end

    // R5 / R6 / R7 trigger mode
    wr(0, 0); wr(3, 0); wr(1, 0); wr(2, 3);
    wr(5, 2); wr(6, 255); wr(7, 5); wr(4, 'h2C); wr(8, 0);
    rd(4, v); check("R11 slave control readback", v, 'h2C);
    rd(5, v); check("R11 slave prescale readback", v, 2);
    rd(6, v); check("R11 slave period readback", v, 255);
    rd(2, v); check("R11 master period readback", v, 3);
    rd(9, v); check("R11 unmapped address", v, 0);
    wr(0, 5);
    rd(0, v); check("R11 master control readback", v, 5);
    for (int n = 1; n <= 34; n++) begin
      step(1);
      rd(7, v);
      check($sformatf("R5 slave count n=%0d", n), v, (n < 4) ? 5 : 5 + (n - 4) / 3);
      rd(4, v);
      check($sformatf("R6 slave enable n=%0d", n), v & 1, (n >= 4) ? 1 : 0);
      rd(8, v);
      check($sformatf("R7 flag n=%0d", n), v, (n >= 4) ? 1 : 0);
    end
    wr(0, 4);
    wr(8, 1);
    rd(8, v); check("R7 write one keeps flag", v, 1);
    wr(8, 0);
    rd(8, v); check("R7 write zero clears flag", v, 0);
    rd(4, v); check("R6 enable kept after master stop", v & 1, 1);
    wr(3, 0); wr(0, 5);
    for (int n = 1; n <= 4; n++) begin
      step(1);
      rd(8, v);
      check($sformatf("R7 retrigger flag n=%0d", n), v, (n >= 4) ? 1 : 0);
      rd(4, v);
      check($sformatf("R6 enable during retrigger n=%0d", n), v & 1, 1);
    end
    wr(0, 4);
    wr(4, 'h2C);
    rd(7, v);
    step(10);
    rd(7, v2); check("R6 software stop holds count", v2, v);
    rd(4, v2); check("R6 software stop clears enable", v2 & 1, 0);

    // R4 non-matching trigger select
    wr(7, 7); wr(8, 0); wr(4, 'h3C); wr(3, 0); wr(0, 5);
    step(12);
    rd(7, v); check("R4 other select count", v, 7);
    rd(4, v); check("R4 other select enable", v, 'h3C);
    rd(8, v); check("R4 other select flag", v, 0);

    // R9 slave control off
    wr(0, 4); wr(4, 'h20); wr(3, 0); wr(0, 5);
    step(12);
    rd(7, v); check("R9 mode off count", v, 7);
    rd(4, v); check("R9 mode off enable", v, 'h20);
    rd(8, v); check("R9 mode off flag", v, 0);

    // R8 gated mode with R3 enable routing
    wr(0, 0); wr(5, 0); wr(7, 10); wr(4, 'h2B); wr(8, 0);
    step(5);
    rd(7, v); check("R8 gated hold while low", v, 10);
    check("R3 trig_out low with master off", int'(trig_out), 0);
    rd(8, v); check("R8 flag before gate", v, 0);
    wr(0, 3);
    check("R3 enable routing", int'(trig_out), 1);
    rd(7, v); check("R8 count at gate open", v, 10);
    rd(8, v); check("R8 flag before rise edge", v, 0);
    for (int n = 1; n <= 8; n++) begin
      step(1);
      rd(7, v); check($sformatf("R8 gated count n=%0d", n), v, 10 + n);
      rd(8, v); check($sformatf("R8 rise flag n=%0d", n), v, 1);
    end
    wr(8, 0);
    rd(7, v); check("R8 count before close", v, 19);
    rd(8, v); check("R7 flag cleared in gated", v, 0);
    wr(0, 2);
    check("R3 trig_out follows master disable", int'(trig_out), 0);
    rd(7, v); check("R8 count at gate close", v, 20);
    rd(8, v); check("R8 flag before fall edge", v, 0);
    step(1);
    rd(7, v); check("R8 count after close", v, 20);
    rd(8, v); check("R8 fall sets flag", v, 1);
    step(5);
    rd(7, v); check("R8 hold while low", v, 20);
    wr(0, 1);
    check("R3 other master mode gives low", int'(trig_out), 0);
    step(3);
    rd(7, v); check("R3 slave holds with trigger low", v, 20);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule